// File: doc/BRIEF.md
# Configuration Port Unlock Sequencer

This block is the configuration front end of a legacy I/O device. It sits behind two byte-wide I/O ports: an index port at a base address and a data port one address above it. After reset it is locked. The only way in is to write a four-byte key to the index port, in the right order. The key's final byte depends on which base port the instance decodes. While locked, the data port does nothing. Writes to it are dropped and reads return all ones.

Once unlocked, a byte written to the index port selects a configuration register, and the data port then reads or writes that register. The register file holds:
- a read-only 16-bit device identifier, split over two registers;
- a logical-device selector;
- a global flash-segment control register, with suspend, three segment enables, host-write enable and pin select;
- a two-byte flash-controller I/O base, visible only when the flash logical device is selected.

Writing the exit code to the exit register locks the block again. The selector, segment control and flash base also leave the block as plain outputs for neighbouring logic.

Top module: `cfg_port_front`

## Requirements
- R1: After reset the block is locked (`cfg_open` = 0), `io_rdata` = 0xFF, the selector is 0x00, segment control is 0x00 and the flash base equals `FLASH_BASE_RST` (default 0x0820).
- R2: Writing 0x87, 0x01, 0x55 and then the final key byte to the index port while locked sets `cfg_open` on the clock edge that takes the fourth write.
- R3: The final key byte is 0x55 when `BASE_PORT` is 0x2E, and 0xAA for any other base (0x4E in use). The other value in fourth place does not unlock.
- R4: A mismatching key byte sends the matcher back to its first step. If that byte is 0x87, it counts as the first key byte. Writes to other I/O addresses leave the matcher untouched.
- R5: While locked, data-port writes change no register, and data-port and index-port reads return 0xFF.
- R6: Register 0x20 reads the identifier's high byte and register 0x21 its low byte (default 0x8716). Writes to them have no effect.
- R7: Writing 0x02 to register 0x02 clears `cfg_open` at that edge. Any other value written there leaves the block open.
- R8: Register 0x07 is the read/write logical-device selector. Registers 0x64 (high byte) and 0x65 (low byte) are the flash base, but only while the selector holds `FLASH_LDN` (default 7). Otherwise they read 0x00 and ignore writes.
- R9: Register 0x24 is global: it is readable and writable whatever the selector holds. Its six low bits are kept (bit 0 suspend, bits 1-3 segment enables, bit 4 host flash write, bit 5 pin select) and bits 7:6 read 0.
- R10: While open, an index-port read returns the current register number, and unimplemented registers read 0x00.
- R11: A read strobe loads `io_rdata` on its clock edge, and `io_rdata` holds that value until the next read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| io_wr | input | 1 | One-cycle I/O write strobe |
| io_rd | input | 1 | One-cycle I/O read strobe |
| io_addr | input | ADDR_W | I/O address of the access |
| io_wdata | input | 8 | Write data byte |
| io_rdata | output | 8 | Registered read data |
| cfg_open | output | 1 | Configuration mode is unlocked |
| ldn_sel | output | 8 | Logical-device selector |
| seg_cfg | output | SEG_W | Flash segment control bits |
| flash_iobase | output | 16 | Flash controller I/O base |

## Verification
Each result is registered once. A write driven before an edge shows in `cfg_open`, `ldn_sel`, `seg_cfg` and `flash_iobase` just after that edge, and a read strobe shows in `io_rdata` just after its edge. No result arrives a cycle later. The bench drives every strobe on a falling edge and drops it on the next falling edge. It compares all outputs at that second falling edge, half a period after the only edge that could change them. It uses a bench-side model of the key matcher and register file for the expected values, so checks never land between two register stages.

// File: rtl/cfg_port_pkg.sv
// Package: shared constants for the configuration port front end.
// Assumes byte-wide I/O data and a four-byte unlock key.
package cfg_port_pkg;

    localparam int KEY_LEN = 4;

    localparam logic [7:0] REG_EXIT   = 8'h02;
    localparam logic [7:0] EXIT_CODE  = 8'h02;
    localparam logic [7:0] REG_LDN    = 8'h07;
    localparam logic [7:0] REG_ID_HI  = 8'h20;
    localparam logic [7:0] REG_ID_LO  = 8'h21;
    localparam logic [7:0] REG_SEG    = 8'h24;
    localparam logic [7:0] REG_FB_HI  = 8'h64;
    localparam logic [7:0] REG_FB_LO  = 8'h65;
    localparam logic [7:0] LOCKED_RD  = 8'hFF;

    // Key byte expected at a given step; the last byte is instance-specific.
    function automatic logic [7:0] key_at(input int step, input logic [7:0] last);
        case (step)
            0:       key_at = 8'h87;
            1:       key_at = 8'h01;
            2:       key_at = 8'h55;
            default: key_at = last;
        endcase
    endfunction

endpackage

// File: rtl/cfg_key_match.sv
// Key matcher: follows index-port bytes written while locked and reports
// a hit when the full key has arrived in order. Assumes `en` is only
// raised for index writes while the block is locked.
module cfg_key_match
    import cfg_port_pkg::*;
#(
    parameter logic [15:0] BASE_PORT = 16'h002E
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic [7:0] byte_in,
    output logic       hit
);
    localparam int         STEP_W   = $clog2(KEY_LEN);
    localparam logic [7:0] LAST_KEY = (BASE_PORT == 16'h002E) ? 8'h55 : 8'hAA;

    logic [STEP_W-1:0] step_q;
    logic [7:0]        want;
    logic              match;

    // Purpose: pick the byte expected at the current step.
    always_comb begin
        want = key_at(int'(step_q), LAST_KEY);
    end

    assign match = en && (byte_in == want);
    assign hit   = match && (step_q == STEP_W'(KEY_LEN - 1));

    // Purpose: advance on a match, restart on a miss (0x87 counts as step one).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q <= '0;
        end else if (en) begin
            if (hit)
                step_q <= '0;
            else if (match)
                step_q <= step_q + STEP_W'(1);
            else if (byte_in == key_at(0, LAST_KEY))
                step_q <= STEP_W'(1);
            else
                step_q <= '0;
        end
    end

endmodule

// File: rtl/cfg_reg_file.sv
// Register file: index register, logical-device selector, global segment
// control and the per-device flash base. Assumes write strobes arrive only
// while configuration mode is open.
module cfg_reg_file
    import cfg_port_pkg::*;
#(
    parameter logic [15:0] CHIP_ID        = 16'h8716,
    parameter logic [7:0]  FLASH_LDN      = 8'h07,
    parameter logic [15:0] FLASH_BASE_RST = 16'h0820,
    parameter int          SEG_W          = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             idx_we,
    input  logic             dat_we,
    input  logic [7:0]       wdata,
    output logic [7:0]       cur_idx,
    output logic [7:0]       rd_val,
    output logic             exit_req,
    output logic [7:0]       ldn_q,
    output logic [SEG_W-1:0] seg_q,
    output logic [15:0]      fbase_q
);
    localparam int NB = 2;

    logic fdev_sel;

    assign fdev_sel = (ldn_q == FLASH_LDN);
    assign exit_req = dat_we && (cur_idx == REG_EXIT) && (wdata == EXIT_CODE);

    // Purpose: hold the register number chosen through the index port.
    always_ff @(posedge clk) begin
        if (!rst_n)      cur_idx <= '0;
        else if (idx_we) cur_idx <= wdata;
    end

    // Purpose: logical-device selector and global segment control.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ldn_q <= '0;
            seg_q <= '0;
        end else if (dat_we) begin
            if (cur_idx == REG_LDN) ldn_q <= wdata;
            if (cur_idx == REG_SEG) seg_q <= wdata[SEG_W-1:0];
        end
    end

    // Purpose: one byte lane of the flash base per generated register.
    for (genvar b = 0; b < NB; b++) begin : g_fbase
        localparam logic [7:0] ADDR = REG_FB_LO - 8'(b);
        always_ff @(posedge clk) begin
            if (!rst_n)
                fbase_q[8*b +: 8] <= FLASH_BASE_RST[8*b +: 8];
            else if (dat_we && fdev_sel && (cur_idx == ADDR))
                fbase_q[8*b +: 8] <= wdata;
        end
    end

    // Purpose: read multiplexer over the implemented registers.
    always_comb begin
        rd_val = 8'h00;
        case (cur_idx)
            REG_LDN:   rd_val = ldn_q;
            REG_ID_HI: rd_val = CHIP_ID[15:8];
            REG_ID_LO: rd_val = CHIP_ID[7:0];
            REG_SEG:   rd_val = 8'(seg_q);
            REG_FB_HI: rd_val = fdev_sel ? fbase_q[15:8] : 8'h00;
            REG_FB_LO: rd_val = fdev_sel ? fbase_q[7:0]  : 8'h00;
            default:   rd_val = 8'h00;
        endcase
    end

endmodule

// File: rtl/cfg_port_front.sv
// Top: decodes the index/data port pair, gates key matching and register
// access by the lock state and registers read data. Assumes single-cycle
// read and write strobes that are never raised together.
module cfg_port_front
    import cfg_port_pkg::*;
#(
    parameter int          ADDR_W         = 16,
    parameter logic [15:0] BASE_PORT      = 16'h002E,
    parameter logic [15:0] CHIP_ID        = 16'h8716,
    parameter logic [7:0]  FLASH_LDN      = 8'h07,
    parameter logic [15:0] FLASH_BASE_RST = 16'h0820,
    parameter int          SEG_W          = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic [7:0]        io_wdata,
    output logic [7:0]        io_rdata,
    output logic              cfg_open,
    output logic [7:0]        ldn_sel,
    output logic [SEG_W-1:0]  seg_cfg,
    output logic [15:0]       flash_iobase
);
    localparam logic [ADDR_W-1:0] IDX_PORT = ADDR_W'(BASE_PORT);
    localparam logic [ADDR_W-1:0] DAT_PORT = ADDR_W'(BASE_PORT) + ADDR_W'(1);

    logic       at_idx, at_dat;
    logic       key_hit, exit_req;
    logic [7:0] cur_idx, rd_val;

    assign at_idx = (io_addr == IDX_PORT);
    assign at_dat = (io_addr == DAT_PORT);

    cfg_key_match #(.BASE_PORT(BASE_PORT)) u_key (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (io_wr && at_idx && !cfg_open),
        .byte_in (io_wdata),
        .hit     (key_hit)
    );

    cfg_reg_file #(
        .CHIP_ID        (CHIP_ID),
        .FLASH_LDN      (FLASH_LDN),
        .FLASH_BASE_RST (FLASH_BASE_RST),
        .SEG_W          (SEG_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .idx_we   (io_wr && at_idx && cfg_open),
        .dat_we   (io_wr && at_dat && cfg_open),
        .wdata    (io_wdata),
        .cur_idx  (cur_idx),
        .rd_val   (rd_val),
        .exit_req (exit_req),
        .ldn_q    (ldn_sel),
        .seg_q    (seg_cfg),
        .fbase_q  (flash_iobase)
    );

    // Purpose: lock state, opened by the key and closed by the exit write.
    always_ff @(posedge clk) begin
        if (!rst_n)        cfg_open <= 1'b0;
        else if (key_hit)  cfg_open <= 1'b1;
        else if (exit_req) cfg_open <= 1'b0;
    end

    // Purpose: capture read data on each read strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            io_rdata <= LOCKED_RD;
        end else if (io_rd) begin
            if (cfg_open && at_idx)      io_rdata <= cur_idx;
            else if (cfg_open && at_dat) io_rdata <= rd_val;
            else                         io_rdata <= LOCKED_RD;
        end
    end

endmodule

// File: rtl/cfg_port_front_chk.sv
// Checker: temporal properties of the configuration front end, attached
// to every instance of the top by the bind at the end of this file.
module cfg_port_front_chk #(
    parameter int          ADDR_W    = 16,
    parameter logic [15:0] BASE_PORT = 16'h002E,
    parameter logic [15:0] CHIP_ID   = 16'h8716,
    parameter logic [7:0]  FLASH_LDN = 8'h07,
    parameter int          SEG_W     = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              io_wr,
    input logic              io_rd,
    input logic [ADDR_W-1:0] io_addr,
    input logic [7:0]        io_wdata,
    input logic [7:0]        io_rdata,
    input logic              cfg_open,
    input logic [7:0]        ldn_sel,
    input logic [SEG_W-1:0]  seg_cfg,
    input logic [15:0]       flash_iobase,
    input logic [7:0]        cur_idx
);
    localparam logic [ADDR_W-1:0] IDX_PORT = ADDR_W'(BASE_PORT);
    localparam logic [ADDR_W-1:0] DAT_PORT = ADDR_W'(BASE_PORT) + ADDR_W'(1);

    a_r2_open_after_index_write: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_open) |-> $past(io_wr && io_addr == IDX_PORT));

    a_r5_locked_read_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && !cfg_open && (io_addr == DAT_PORT || io_addr == IDX_PORT)) |=> io_rdata == 8'hFF);

    a_r5_locked_regs_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_open |=> ($stable(ldn_sel) && $stable(seg_cfg) && $stable(flash_iobase)));

    a_r6_id_high_read: assert property (@(posedge clk) disable iff (!rst_n)
        (io_rd && cfg_open && io_addr == DAT_PORT && cur_idx == 8'h20) |=> io_rdata == CHIP_ID[15:8]);

    a_r7_close_on_exit_write: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cfg_open) |-> $past(io_wr && io_addr == DAT_PORT && io_wdata == 8'h02 && cur_idx == 8'h02));

    a_r8_base_needs_device: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_wr && cfg_open && io_addr == DAT_PORT && ldn_sel == FLASH_LDN) |=> $stable(flash_iobase));

    a_r11_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !io_rd |=> $stable(io_rdata));

endmodule

bind cfg_port_front cfg_port_front_chk #(
    .ADDR_W    (ADDR_W),
    .BASE_PORT (BASE_PORT),
    .CHIP_ID   (CHIP_ID),
    .FLASH_LDN (FLASH_LDN),
    .SEG_W     (SEG_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .io_wr        (io_wr),
    .io_rd        (io_rd),
    .io_addr      (io_addr),
    .io_wdata     (io_wdata),
    .io_rdata     (io_rdata),
    .cfg_open     (cfg_open),
    .ldn_sel      (ldn_sel),
    .seg_cfg      (seg_cfg),
    .flash_iobase (flash_iobase),
    .cur_idx      (cur_idx)
);

// File: tb/cfg_port_front_test.sv
// Bench: two instances on one I/O bus (bases 0x2E and 0x4E), directed
// corner cases then seeded random traffic against a bench-side model.
module cfg_port_front_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_wr = 1'b0, io_rd = 1'b0;
    logic [15:0] io_addr = '0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  a_rdata, b_rdata, a_ldn, b_ldn;
    logic        a_open, b_open;
    logic [5:0]  a_seg, b_seg;
    logic [15:0] a_fb, b_fb;

    int checks = 0, fails = 0;
    bit done = 0;

    always #5 clk = ~clk;

    cfg_port_front uut (
        .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_rd(io_rd), .io_addr(io_addr),
        .io_wdata(io_wdata), .io_rdata(a_rdata), .cfg_open(a_open), .ldn_sel(a_ldn),
        .seg_cfg(a_seg), .flash_iobase(a_fb));

    cfg_port_front #(.BASE_PORT(16'h004E)) uut_b (
        .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_rd(io_rd), .io_addr(io_addr),
        .io_wdata(io_wdata), .io_rdata(b_rdata), .cfg_open(b_open), .ldn_sel(b_ldn),
        .seg_cfg(b_seg), .flash_iobase(b_fb));

    // Model of instance A (base 0x2E).
    bit        m_open = 0;
    int        m_step = 0;
    logic [7:0]  m_idx = 0, m_ldn = 0;
    logic [5:0]  m_seg = 0;
    logic [15:0] m_fb = 16'h0820;
    bit        mb_open = 0;   // instance B, directed only

    function automatic logic [7:0] m_key(int s);
        case (s) 0: return 8'h87; 1: return 8'h01; 2: return 8'h55; default: return 8'h55; endcase
    endfunction

    function automatic logic [7:0] m_reg();
        case (m_idx)
            8'h07: return m_ldn;
            8'h20: return 8'h87;
            8'h21: return 8'h16;
            8'h24: return {2'b00, m_seg};
            8'h64: return (m_ldn == 8'h07) ? m_fb[15:8] : 8'h00;
            8'h65: return (m_ldn == 8'h07) ? m_fb[7:0]  : 8'h00;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [7:0] m_read(logic [15:0] a);
        if (m_open && a == 16'h002E) return m_idx;
        if (m_open && a == 16'h002F) return m_reg();
        return 8'hFF;
    endfunction

    task automatic m_write(logic [15:0] a, logic [7:0] d);
        if (a == 16'h002E) begin
            if (m_open) m_idx = d;
            else if (d == m_key(m_step)) begin
                if (m_step == 3) begin m_open = 1; m_step = 0; end
                else m_step++;
            end else m_step = (d == 8'h87) ? 1 : 0;
        end else if (a == 16'h002F && m_open) begin
            case (m_idx)
                8'h02: if (d == 8'h02) m_open = 0;
                8'h07: m_ldn = d;
                8'h24: m_seg = d[5:0];
                8'h64: if (m_ldn == 8'h07) m_fb[15:8] = d;
                8'h65: if (m_ldn == 8'h07) m_fb[7:0] = d;
                default: ;
            endcase
        end
    endtask

    task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic chk_state(string req);
        chk(req, 16'(a_open), 16'(m_open));
        chk(req, 16'(b_open), 16'(mb_open));
        chk({req, " R8"}, 16'(a_ldn), 16'(m_ldn));
        chk({req, " R9"}, 16'(a_seg), 16'(m_seg));
        chk({req, " R8"}, a_fb, m_fb);
    endtask

    task automatic wr(logic [15:0] a, logic [7:0] d, string req);
        @(negedge clk);
        io_addr = a; io_wdata = d; io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
        m_write(a, d);
        chk_state(req);
    endtask

    task automatic rd(logic [15:0] a, string req);
        @(negedge clk);
        io_addr = a; io_rd = 1'b1;
        @(negedge clk);
        io_rd = 1'b0;
        if (a[15:4] == 12'h004) chk(req, 16'(b_rdata), 16'(mb_open ? 8'h00 : 8'hFF));
        else                    chk(req, 16'(a_rdata), 16'(m_read(a)));
    endtask

    task automatic key_a(logic [7:0] last, string req);
        wr(16'h002E, 8'h87, req); wr(16'h002E, 8'h01, req);
        wr(16'h002E, 8'h55, req); wr(16'h002E, last, req);
    endtask

    task automatic wreg(logic [7:0] r, logic [7:0] d, string req);
        wr(16'h002E, r, req); wr(16'h002F, d, req);
    endtask

    task automatic rreg(logic [7:0] r, string req);
        wr(16'h002E, r, req); rd(16'h002F, req);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk_state("R1");
        chk("R1", 16'(a_rdata), 16'h00FF);
        chk("R1", 16'(b_rdata), 16'h00FF);
        // R5 locked: reads all ones, data writes dropped
        rd(16'h002F, "R5"); rd(16'h002E, "R5");
        wr(16'h002F, 8'h3F, "R5");
        // R11 rdata holds without a read strobe
        wr(16'h0080, 8'h00, "R11");
        chk("R11", 16'(a_rdata), 16'h00FF);
        // R3 wrong fourth byte for base 0x2E
        key_a(8'hAA, "R3");
        // R4 mismatch then restart via 0x87
        wr(16'h002E, 8'h87, "R4"); wr(16'h002E, 8'h01, "R4");
        wr(16'h002E, 8'h87, "R4"); wr(16'h002E, 8'h01, "R4");
        wr(16'h002E, 8'h55, "R4"); wr(16'h004E, 8'h12, "R4 other port");
        wr(16'h002E, 8'h55, "R4 R2");
        chk("R4", 16'(a_open), 16'h0001);
        wreg(8'h02, 8'h02, "R7");
        chk("R7", 16'(a_open), 16'h0000);
        wr(16'h002E, 8'h87, "R4"); wr(16'h002E, 8'h01, "R4");
        wr(16'h002E, 8'h55, "R4"); wr(16'h002E, 8'h12, "R4");
        wr(16'h002E, 8'h55, "R4");
        chk("R4", 16'(a_open), 16'h0000);
        // R3 instance B: 0x55 last fails, 0xAA last opens
        wr(16'h004E, 8'h87, "R3"); wr(16'h004E, 8'h01, "R3");
        wr(16'h004E, 8'h55, "R3"); wr(16'h004E, 8'h55, "R3");
        wr(16'h004E, 8'h87, "R3"); wr(16'h004E, 8'h01, "R3");
        wr(16'h004E, 8'h55, "R3"); mb_open = 1; wr(16'h004E, 8'hAA, "R3");
        wr(16'h004E, 8'h02, "R7"); mb_open = 0; wr(16'h004F, 8'h02, "R7");
        // R2 open instance A
        key_a(8'h55, "R2");
        // R6 identifier, read only
        rreg(8'h20, "R6"); rreg(8'h21, "R6");
        wreg(8'h20, 8'h00, "R6"); rd(16'h002F, "R6");
        // R10 index read back and unimplemented register
        rd(16'h002E, "R10"); rreg(8'h30, "R10");
        // R8 flash base only with device 7
        wreg(8'h07, 8'h03, "R8"); wreg(8'h64, 8'hAB, "R8"); rd(16'h002F, "R8");
        wreg(8'h07, 8'h07, "R8"); rreg(8'h64, "R8"); rreg(8'h65, "R8");
        wreg(8'h64, 8'h12, "R8"); wreg(8'h65, 8'h34, "R8"); rd(16'h002F, "R8");
        rreg(8'h07, "R8");
        // R9 global segment control, upper bits read zero
        wreg(8'h07, 8'h01, "R9"); wreg(8'h24, 8'hFF, "R9"); rd(16'h002F, "R9");
        // R7 non-exit value leaves it open, exit code closes
        wreg(8'h02, 8'h03, "R7"); wreg(8'h02, 8'h02, "R7");
        rd(16'h002F, "R5");
        // Random phase
        for (int n = 0; n < 1500; n++) begin
            int op;
            logic [7:0] v;
            op = $urandom_range(0, 9);
            case ($urandom_range(0, 12))
                0: v = 8'h87;  1: v = 8'h01;  2: v = 8'h55;  3: v = 8'hAA;
                4: v = 8'h02;  5: v = 8'h07;  6: v = 8'h20;  7: v = 8'h21;
                8: v = 8'h24;  9: v = 8'h64;  10: v = 8'h65; 11: v = 8'h30;
                default: v = 8'($urandom);
            endcase
            if (op <= 2)      wr(16'h002E, v, "R2 R4 random index");
            else if (op <= 4) wr(16'h002F, (op == 4) ? 8'($urandom) : v, "R8 R9 random data");
            else if (op <= 6) rd(16'h002F, "R10 random data read");
            else if (op == 7) rd(16'h002E, "R10 random index read");
            else if (op == 8) key_a(8'h55, "R2 random key");
            else              wr(16'h004F, v, "R5 other instance");
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule